// File: doc/BRIEF.md
# Serial Port Byte Queue Pair with Trigger Levels

This block holds the two byte queues that sit between a processor and the shifter of an asynchronous serial port. One queue carries outgoing bytes, and the other carries incoming bytes. Each queue has its own control register. A control register has an enable bit, a flush bit that clears itself, and a 6-bit trigger level. The block also has one read-only status word. It reports how full each queue is and how many transmit slots are still free.

Software feeds the transmit queue with single-byte writes to a data address. Before each write, it polls the free-slot field in the status word. The shifter takes transmit bytes over a valid/ready handshake. A byte leaves only in a cycle where both valid and ready are high. The shifter may hold ready low for as long as it likes, and the head byte then stays on the data pins.

Received bytes arrive as single-cycle strobes, and that input has no ready signal. When the receive queue is full, the byte is lost and an overrun pulse is raised. Software drains received bytes one at a time, up to the fill level it last read from the status word. A transmit request and a receive request compare each fill level against that queue's trigger level.

Top module: `sfp_top`

## Requirements
- R1: After reset, both control words read 0. The status word reads 0x1000_0000 (both fills 0, free count 16). tx_out_valid, tx_req, rx_req and rx_overrun are low, and tx_empty is high.
- R2: Register address 0 holds the transmit control word and address 1 holds the receive control word. In each, the enable flag is bit 0, the flush flag is bit 1 and the trigger level is bits 13:8. All other bits read 0.
- R3: The status word sits at address 2 and is read-only. Bits 5:0 hold the receive fill, bits 13:8 hold the transmit fill, and bits 29:24 hold the transmit free count, which equals 16 minus the transmit fill. All other bits read 0.
- R4: A write to address 3 appends wdata[7:0] to the transmit queue, but only when the transmit queue is enabled and its free count is nonzero. Otherwise the write is ignored and both fill and free stay unchanged.
- R5: tx_out_valid is high whenever the transmit queue is enabled and its fill is above 0, and tx_out_data then shows the oldest byte. A valid&ready cycle removes that byte. Bytes leave in the order they were written. While ready is low, the data stays stable.
- R6: A cycle with rx_in_valid high and the receive queue enabled and not full stores rx_in_data. A read at address 4 shows the oldest received byte in the same cycle, and reg_rd removes it. Reading an empty receive queue returns 0 and changes nothing.
- R7: A received byte that arrives while the receive queue is full is dropped, and rx_overrun pulses high for exactly the next cycle. While the receive queue is disabled, arriving bytes are dropped with no overrun pulse.
- R8: Writing 1 to a flush bit makes that bit read 1 for one cycle. In the following cycle the queue is empty: its fill is 0, and for transmit the free count is 16. The flush bit then reads 0 and the enable flag keeps its written value.
- R9: A single control write that clears enable and sets flush leaves that queue empty and disabled.
- R10: rx_req is high exactly when the receive queue is enabled and its fill is greater than or equal to its trigger level.
- R11: tx_req is high exactly when the transmit queue is enabled and its fill is less than or equal to its trigger level.
- R12: tx_empty is high exactly when the transmit fill is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a byte at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_out_valid | output | 1 | Transmit byte available to the shifter |
| tx_out_ready | input | 1 | Shifter accepts the byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| rx_in_valid | input | 1 | Received byte strobe from the shifter |
| rx_in_data | input | 8 | Received byte |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| rx_overrun | output | 1 | One-cycle pulse for a dropped received byte |

## Verification
The hardest state to reach is the boundary where the receive queue is full. That is where the overrun pulse can fire, and where the receive request meets its highest trigger levels. It is reached only after sixteen strobes, with nothing read back in between. The bench steps each queue one byte at a time from empty to full. At every fill level it rewrites the trigger level from 0 to 17 and checks both requests against arithmetic comparisons. It then sends one extra byte at full and one extra write at full. The flush window is only one cycle long, so the bench samples it on the clock right after the control write.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [2:0] {
    A_TX_CTRL = 3'd0,
    A_RX_CTRL = 3'd1,
    A_STATUS  = 3'd2,
    A_TX_DATA = 3'd3,
    A_RX_DATA = 3'd4
  } sfp_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_FL_BIT  = 1;
  localparam int CTRL_LVL_LSB = 8;
  localparam int ST_RXF_LSB   = 0;
  localparam int ST_TXF_LSB   = 8;
  localparam int ST_FREE_LSB  = 24;
  localparam int REG_W        = 32;
  localparam int CH_TX        = 0;
  localparam int CH_RX        = 1;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clear) |=> full);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             en,
  output logic             flush,
  output logic [LVL_W-1:0] level,
  output logic [REG_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      flush <= 1'b0;
      level <= '0;
    end else if (wr) begin
      en    <= wdata[CTRL_EN_BIT];
      flush <= wdata[CTRL_FL_BIT];
      level <= wdata[CTRL_LVL_LSB +: LVL_W];
    end else begin
      flush <= 1'b0;
    end
  end

  always_comb begin
    word = '0;
    word[CTRL_EN_BIT] = en;
    word[CTRL_FL_BIT] = flush;
    word[CTRL_LVL_LSB +: LVL_W] = level;
  end

  assert_flush_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !flush);
endmodule

// File: rtl/sfp_top.sv
module sfp_top
  import sfp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_empty,
  output logic              rx_overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]             ctrl_wr, ch_en, ch_flush;
  logic [LVL_W-1:0]       ch_level [2];
  logic [REG_W-1:0]       ch_word  [2];
  logic [CNT_W-1:0]       tx_cnt, rx_cnt;
  logic [LVL_W-1:0]       tx_fill, rx_fill, tx_free;
  logic                   tx_full, rx_full, rx_empty, tx_fifo_empty;
  logic                   tx_push, tx_pop, rx_push, rx_pop;
  logic [DATA_W-1:0]      rx_head;
  logic [REG_W-1:0]       status_word;
  logic                   overrun_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ctrl
    localparam logic [2:0] MY_ADDR = (ch == CH_TX) ? A_TX_CTRL : A_RX_CTRL;
    assign ctrl_wr[ch] = reg_wr && (reg_addr == MY_ADDR);
    sfp_ctrl #(.LVL_W(LVL_W)) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr[ch]),
      .wdata (reg_wdata),
      .en    (ch_en[ch]),
      .flush (ch_flush[ch]),
      .level (ch_level[ch]),
      .word  (ch_word[ch])
    );
  end

  assign tx_push = reg_wr && (reg_addr == A_TX_DATA) && ch_en[CH_TX];
  assign tx_pop  = tx_out_valid && tx_out_ready;
  assign rx_push = rx_in_valid && ch_en[CH_RX];
  assign rx_pop  = reg_rd && (reg_addr == A_RX_DATA);

  sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ch_flush[CH_TX]),
    .push  (tx_push),
    .din   (reg_wdata[DATA_W-1:0]),
    .pop   (tx_pop),
    .dout  (tx_out_data),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_fifo_empty)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ch_flush[CH_RX]),
    .push  (rx_push),
    .din   (rx_in_data),
    .pop   (rx_pop),
    .dout  (rx_head),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_fill      = LVL_W'(tx_cnt);
  assign rx_fill      = LVL_W'(rx_cnt);
  assign tx_free      = LVL_W'(DEPTH) - tx_fill;
  assign tx_empty     = tx_fifo_empty;
  assign tx_out_valid = ch_en[CH_TX] && !tx_fifo_empty;
  assign tx_req       = ch_en[CH_TX] && (tx_fill <= ch_level[CH_TX]);
  assign rx_req       = ch_en[CH_RX] && (rx_fill >= ch_level[CH_RX]);

  always_comb begin
    status_word = '0;
    status_word[ST_RXF_LSB  +: LVL_W] = rx_fill;
    status_word[ST_TXF_LSB  +: LVL_W] = tx_fill;
    status_word[ST_FREE_LSB +: LVL_W] = tx_free;
  end

  always_comb begin
    case (reg_addr)
      A_TX_CTRL: reg_rdata = ch_word[CH_TX];
      A_RX_CTRL: reg_rdata = ch_word[CH_RX];
      A_STATUS:  reg_rdata = status_word;
      A_RX_DATA: reg_rdata = 32'(rx_head);
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_q <= 1'b0;
    else        overrun_q <= rx_push && rx_full;
  end
  assign rx_overrun = overrun_q;

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && !ctrl_wr[CH_TX] && !ch_flush[CH_TX])
      |=> (tx_out_valid && $stable(tx_out_data)));
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_full));
  assert_free_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_free) + 32'(tx_fill)) == 32'(DEPTH));
  assert_rx_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !rx_push) |=> (rx_cnt == '0));
endmodule

// File: tb/test_sfp_top.sv
module test_sfp_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        tx_out_valid, tx_out_ready = 1'b0;
  logic [7:0]  tx_out_data;
  logic        rx_in_valid = 1'b0;
  logic [7:0]  rx_in_data = 8'd0;
  logic        tx_req, rx_req, tx_empty, rx_overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  sfp_top i_sfp_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .rx_in_valid(rx_in_valid),
    .rx_in_data(rx_in_data), .tx_req(tx_req), .rx_req(rx_req),
    .tx_empty(tx_empty), .rx_overrun(rx_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    reg_addr = 3'd4; reg_rd = 1'b1;
    #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_in_data = b; rx_in_valid = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  function automatic logic [31:0] status_of(int rxf, int txf);
    return (32'(DEPTH - txf) << 24) | (32'(txf) << 8) | 32'(rxf);
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd0, d); chk("R1 tx ctrl", d, 32'h0);
    peek(3'd1, d); chk("R1 rx ctrl", d, 32'h0);
    peek(3'd2, d); chk("R1 status", d, 32'h1000_0000);
    chk("R1 tx_out_valid", 32'(tx_out_valid), 0);
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 rx_req", 32'(rx_req), 0);
    chk("R1 tx_empty", 32'(tx_empty), 1);
    chk("R1 rx_overrun", 32'(rx_overrun), 0);

    // R2 control layout, unused bits read zero
    wr_reg(3'd0, 32'hFFFF_FFFD);
    peek(3'd0, d); chk("R2 tx ctrl readback", d, 32'h0000_3F01);
    wr_reg(3'd1, 32'hA5A5_2A00);
    peek(3'd1, d); chk("R2 rx ctrl readback", d, 32'h0000_2A00);
    wr_reg(3'd1, 32'h0);

    // R4 disabled transmit queue ignores data writes; R11 no request while disabled
    wr_reg(3'd0, 32'h0000_3F00);
    chk("R11 tx_req disabled", 32'(tx_req), 0);
    wr_reg(3'd3, 32'h55);
    peek(3'd2, d); chk("R4 disabled write ignored", d, status_of(0, 0));

    // transmit sweep over fill and trigger level
    for (int n = 0; n <= DEPTH; n++) begin
      peek(3'd2, d); chk("R3 status tx fill/free", d, status_of(0, n));
      for (int lvl = 0; lvl <= 17; lvl++) begin
        wr_reg(3'd0, 32'h1 | (32'(lvl) << 8));
        chk("R11 tx_req", 32'(tx_req), 32'(n <= lvl));
      end
      chk("R12 tx_empty", 32'(tx_empty), 32'(n == 0));
      chk("R5 tx_out_valid", 32'(tx_out_valid), 32'(n > 0));
      if (n > 0) chk("R5 head stable while not ready", 32'(tx_out_data), 32'hA0);
      if (n < DEPTH) wr_reg(3'd3, 32'hA0 + 32'(n));
    end
    wr_reg(3'd3, 32'hEE);
    peek(3'd2, d); chk("R4 write at full ignored", d, status_of(0, DEPTH));

    // R5 drain in order
    tx_out_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk("R5 tx order", 32'(tx_out_data), 32'hA0 + 32'(i));
      chk("R5 valid while draining", 32'(tx_out_valid), 1);
      @(negedge clk);
    end
    tx_out_ready = 1'b0;
    chk("R5 valid low after drain", 32'(tx_out_valid), 0);
    chk("R12 empty after drain", 32'(tx_empty), 1);

    // receive sweep
    for (int n = 0; n <= DEPTH; n++) begin
      peek(3'd2, d); chk("R3 status rx fill", d, status_of(n, 0));
      for (int lvl = 0; lvl <= 17; lvl++) begin
        wr_reg(3'd1, 32'h1 | (32'(lvl) << 8));
        chk("R10 rx_req", 32'(rx_req), 32'(n >= lvl));
      end
      if (n < DEPTH) begin
        send_rx(8'h50 + 8'(n));
        chk("R7 no overrun below full", 32'(rx_overrun), 0);
      end
    end
    send_rx(8'hEE);
    chk("R7 overrun pulse", 32'(rx_overrun), 1);
    peek(3'd2, d); chk("R7 byte dropped at full", d, status_of(DEPTH, 0));
    @(negedge clk);
    chk("R7 overrun one cycle", 32'(rx_overrun), 0);

    for (int i = 0; i < DEPTH; i++) begin
      pop_rx(d);
      chk("R6 rx order", d, 32'h50 + 32'(i));
    end
    pop_rx(d); chk("R6 empty read returns zero", d, 32'h0);
    peek(3'd2, d); chk("R6 empty read no change", d, status_of(0, 0));

    // R7 disabled receive queue drops silently
    wr_reg(3'd1, 32'h0);
    send_rx(8'h77);
    chk("R7 disabled no overrun", 32'(rx_overrun), 0);
    peek(3'd2, d); chk("R7 disabled drop", d, status_of(0, 0));

    // R8 transmit flush
    wr_reg(3'd0, 32'h0000_0401);
    for (int i = 0; i < 5; i++) wr_reg(3'd3, 32'(i));
    wr_reg(3'd0, 32'h0000_0403);
    peek(3'd0, d); chk("R8 flush bit visible", d, 32'h0000_0403);
    @(negedge clk);
    peek(3'd0, d); chk("R8 flush self-clear", d, 32'h0000_0401);
    peek(3'd2, d); chk("R8 fill zero free full", d, status_of(0, 0));
    chk("R8 tx_out_valid after flush", 32'(tx_out_valid), 0);

    // R9 disable with flush on the receive queue
    wr_reg(3'd1, 32'h1);
    for (int i = 0; i < 3; i++) send_rx(8'h30 + 8'(i));
    peek(3'd2, d); chk("R9 pre-fill", d, status_of(3, 0));
    wr_reg(3'd1, 32'h2);
    @(negedge clk);
    peek(3'd2, d); chk("R9 emptied", d, status_of(0, 0));
    peek(3'd1, d); chk("R9 disabled", d, 32'h0);
    send_rx(8'h99);
    peek(3'd2, d); chk("R9 stays empty", d, status_of(0, 0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule